// File: doc/BRIEF.md
# Edge-Triggered External Interrupt Controller

This block watches a set of external input lines, grouped in banks of 32, and turns selected signal transitions into latched interrupt requests. Each line can be armed to react to a rising transition, a falling transition, or both. A transition on an armed line sets that line's pending flag, which stays set until software clears it by writing a one to its bit in the pending register. Software can also set a pending flag directly through a software trigger register.

Pending flags are gated by a per-line interrupt enable mask and ORed into a single level-sensitive interrupt request. Clearing an enable bit hides a pending flag from the request without discarding it. A per-line event enable register is kept as plain storage for later routing. All registers sit on a simple single-cycle register bus with combinational read data. With one bank the registers use a compact map. With two or three banks they use a split map, in which the trigger-select registers and the mask/pending registers live in two separate regions.

The input lines are assumed to be already synchronous to `clk`. Edges are found by comparing each line with its value one clock earlier.

Top module: `edge_irq_ctrl`

## Requirements
- R1: After reset every register reads zero and `irq` is low; lines that are held high through reset and stay steady do not set any pending flag.
- R2: A line whose rising-select bit is 1 and falling-select bit is 0 sets its pending bit in the cycle after a 0-to-1 change, and not after a 1-to-0 change.
- R3: A line whose falling-select bit is 1 and rising-select bit is 0 sets its pending bit in the cycle after a 1-to-0 change, and not after a 0-to-1 change.
- R4: A line with both select bits set latches pending on either kind of change.
- R5: A line with neither select bit set never becomes pending through its input, whatever the input does.
- R6: Writing a word to a pending register clears each pending bit written as 1 and leaves the bits written as 0 unchanged.
- R7: If an armed edge and a clearing write hit the same pending bit in the same cycle, the bit stays set.
- R8: Writing 1 to a software-trigger bit sets that line's pending bit in the next cycle, regardless of the select bits. The software-trigger register always reads zero.
- R9: `irq` is high exactly when some pending bit has its interrupt-enable bit set. An enable bit of 0 blocks its line from `irq` but keeps the pending flag.
- R10: The interrupt enable, event enable, rising-select and falling-select registers read back the last word written, including zero.
- R11: Reads of unmapped or misaligned byte addresses return zero, and writes to them change no register.
- R12: With one bank the word offsets are: interrupt enable 0x00, event enable 0x04, rising select 0x08, falling select 0x0C, software trigger 0x10, pending 0x14. With two or three banks, bank b (0..2) uses rising select 0x00+0x20·b, falling select 0x04+0x20·b, software trigger 0x08+0x20·b, interrupt enable 0x80+0x10·b, event enable 0x84+0x10·b and pending 0x88+0x10·b.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | ADDR_W | Byte address for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| line_in | input | NUM_BANKS*32 | External lines, bank b at bits [32b+31:32b] |
| irq | output | 1 | Level interrupt request |

## Verification
A stuck or wrong previous-sample bit shows up as a spurious or missing pending flag. It appears on the read port one cycle after the line moves, and on `irq` in that same cycle if the line is enabled. A decoder fault aims a write at the wrong bank or register. The next read of the whole map catches it, because the bench compares every register of every bank against its own model. Random line toggles mixed with random writes move the model and the design together, so an error in the clear/set/edge priority shows at the first cycle where two of them meet on one bit.

// File: rtl/eirq_pkg.sv
// Package: shared constants and types for the edge interrupt controller.
// Assumes: every bank serves a fixed count of lines, one bit per line per register.
package eirq_pkg;

    localparam int LINES_PER_BANK = 32;
    localparam int MAX_BANKS      = 3;
    localparam int BANK_IDX_W     = 2;

    // Register kinds a bus address may select.
    typedef enum logic [2:0] {
        RK_NONE  = 3'd0,
        RK_IMASK = 3'd1,
        RK_EMASK = 3'd2,
        RK_RISE  = 3'd3,
        RK_FALL  = 3'd4,
        RK_SWT   = 3'd5,
        RK_PEND  = 3'd6
    } reg_kind_e;

    // Result of address decoding.
    typedef struct packed {
        logic                  hit;
        logic [BANK_IDX_W-1:0] bank;
        reg_kind_e             kind;
    } reg_sel_t;

endpackage

// File: rtl/eirq_addr_decode.sv
// Module: eirq_addr_decode
// Maps a byte address onto (bank, register kind). One bank uses the compact
// map; two or more banks use the split map with the trigger selects in the
// low region and the mask/pending registers above 0x80.
// Assumes: word-aligned accesses only; misaligned or out-of-range addresses miss.
module eirq_addr_decode
    import eirq_pkg::*;
#(
    parameter int NUM_BANKS = 3,
    parameter int ADDR_W    = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_t          sel
);

    localparam int HI_W = (ADDR_W > 8) ? ADDR_W - 8 : 1;

    logic [7:0]  lo;
    logic        hi_zero;
    logic        aligned;

    // Split the address into the decoded byte and the must-be-zero upper part.
    always_comb begin
        lo      = addr[7:0];
        hi_zero = ((addr >> 8) == '0);
        aligned = (addr[1:0] == 2'b00);
    end

    generate
        if (NUM_BANKS == 1) begin : g_flat
            // Compact map for a single bank.
            always_comb begin
                sel      = '0;
                sel.kind = RK_NONE;
                if (hi_zero && aligned) begin
                    unique case (lo)
                        8'h00:   sel.kind = RK_IMASK;
                        8'h04:   sel.kind = RK_EMASK;
                        8'h08:   sel.kind = RK_RISE;
                        8'h0C:   sel.kind = RK_FALL;
                        8'h10:   sel.kind = RK_SWT;
                        8'h14:   sel.kind = RK_PEND;
                        default: sel.kind = RK_NONE;
                    endcase
                end
                sel.hit = (sel.kind != RK_NONE);
            end
        end else begin : g_split
            logic [BANK_IDX_W-1:0] bidx;
            reg_kind_e             k;

            // Split map: stride 0x20 for selects, stride 0x10 for mask/pending.
            always_comb begin
                k    = RK_NONE;
                bidx = '0;
                if (hi_zero && aligned) begin
                    if (!lo[7]) begin
                        bidx = lo[6:5];
                        unique case (lo[4:0])
                            5'h00:   k = RK_RISE;
                            5'h04:   k = RK_FALL;
                            5'h08:   k = RK_SWT;
                            default: k = RK_NONE;
                        endcase
                    end else if (!lo[6]) begin
                        bidx = lo[5:4];
                        unique case (lo[3:0])
                            4'h0:    k = RK_IMASK;
                            4'h4:    k = RK_EMASK;
                            4'h8:    k = RK_PEND;
                            default: k = RK_NONE;
                        endcase
                    end
                end
                sel.bank = bidx;
                sel.hit  = (k != RK_NONE) && (int'(bidx) < NUM_BANKS);
                sel.kind = sel.hit ? k : RK_NONE;
            end
        end
    endgenerate

endmodule

// File: rtl/eirq_edge_det.sv
// Module: eirq_edge_det
// Compares each line with its value one clock earlier and reports armed
// transitions. The previous sample is loaded every cycle, reset included, so
// the first cycle after reset compares against the live input and sees no edge.
// Assumes: lines are already synchronous to clk.
module eirq_edge_det #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] line_i,
    input  logic [WIDTH-1:0] rise_sel,
    input  logic [WIDTH-1:0] fall_sel,
    output logic [WIDTH-1:0] edge_o
);

    logic [WIDTH-1:0] line_q;

    // Previous-sample register; tracks the input in and out of reset.
    always_ff @(posedge clk) begin
        line_q <= line_i;
    end

    // Armed transitions: rising where selected, falling where selected.
    always_comb begin
        edge_o = (line_i & ~line_q & rise_sel) | (~line_i & line_q & fall_sel);
    end

endmodule

// File: rtl/eirq_bank.sv
// Module: eirq_bank
// Holds one bank's registers: interrupt enable, event enable, rising and
// falling selects, and the pending flags. Pending bits set on armed edges and
// software triggers and clear on write-one-to-clear. A new edge beats a clear.
// Assumes: at most one register write per cycle, selected by wr_kind.
module eirq_bank
    import eirq_pkg::*;
#(
    parameter int WIDTH = LINES_PER_BANK
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] line_i,
    input  logic             wr_en,
    input  reg_kind_e        wr_kind,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] imask_o,
    output logic [WIDTH-1:0] emask_o,
    output logic [WIDTH-1:0] rise_o,
    output logic [WIDTH-1:0] fall_o,
    output logic [WIDTH-1:0] pend_o
);

    logic [WIDTH-1:0] imask_q, emask_q, rise_q, fall_q, pend_q, pend_d;
    logic [WIDTH-1:0] edge_hit;
    logic             clr_wr, swt_wr;

    eirq_edge_det #(.WIDTH(WIDTH)) u_edge (
        .clk      (clk),
        .line_i   (line_i),
        .rise_sel (rise_q),
        .fall_sel (fall_q),
        .edge_o   (edge_hit)
    );

    // Decode which write side effect applies this cycle.
    always_comb begin
        clr_wr = wr_en && (wr_kind == RK_PEND);
        swt_wr = wr_en && (wr_kind == RK_SWT);
    end

    // Configuration registers: plain read/write storage, zero after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            imask_q <= '0;
            emask_q <= '0;
            rise_q  <= '0;
            fall_q  <= '0;
        end else if (wr_en) begin
            case (wr_kind)
                RK_IMASK: imask_q <= wdata;
                RK_EMASK: emask_q <= wdata;
                RK_RISE:  rise_q  <= wdata;
                RK_FALL:  fall_q  <= wdata;
                default:  ;
            endcase
        end
    end

    // Pending next state: clear first, then OR in software sets and edges.
    always_comb begin
        pend_d = pend_q;
        if (clr_wr) pend_d = pend_d & ~wdata;
        if (swt_wr) pend_d = pend_d | wdata;
        pend_d = pend_d | edge_hit;
    end

    // Pending flag register.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    // Drive the register view outward.
    always_comb begin
        imask_o = imask_q;
        emask_o = emask_q;
        rise_o  = rise_q;
        fall_o  = fall_q;
        pend_o  = pend_q;
    end

    AST_PEND_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && edge_hit == '0) |=> $stable(pend_q)); // R5
    AST_EDGE_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_hit != '0) |=> ((pend_q & $past(edge_hit)) == $past(edge_hit))); // R7
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && edge_hit == '0) |=> ((pend_q & $past(wdata)) == '0)); // R6
    AST_SWT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        swt_wr |=> ((pend_q & $past(wdata)) == $past(wdata))); // R8

endmodule

// File: rtl/edge_irq_ctrl.sv
// Module: edge_irq_ctrl (top)
// Banks of edge-armed pending flags behind a single-cycle register bus, with
// one level interrupt built from pending AND interrupt enable over all lines.
// Assumes: 1 to 3 banks; bus_addr is a byte address; reads are combinational.
module edge_irq_ctrl
    import eirq_pkg::*;
#(
    parameter int NUM_BANKS = 3,
    parameter int ADDR_W    = 8
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                bus_wr,
    input  logic [ADDR_W-1:0]                   bus_addr,
    input  logic [31:0]                         bus_wdata,
    output logic [31:0]                         bus_rdata,
    input  logic [NUM_BANKS*LINES_PER_BANK-1:0] line_in,
    output logic                                irq
);

    localparam int LW = LINES_PER_BANK;

    reg_sel_t          sel;
    logic [LW-1:0]     imask_a [NUM_BANKS];
    logic [LW-1:0]     emask_a [NUM_BANKS];
    logic [LW-1:0]     rise_a  [NUM_BANKS];
    logic [LW-1:0]     fall_a  [NUM_BANKS];
    logic [LW-1:0]     pend_a  [NUM_BANKS];
    logic [NUM_BANKS-1:0] bank_req;
    logic [NUM_BANKS-1:0] bank_en_any;
    logic [NUM_BANKS-1:0] bank_pend_any;

    eirq_addr_decode #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            logic bank_wr;

            // Route the write strobe to the addressed bank only.
            always_comb begin
                bank_wr = bus_wr && sel.hit && (sel.bank == BANK_IDX_W'(b));
            end

            eirq_bank #(.WIDTH(LW)) u_bank (
                .clk     (clk),
                .rst_n   (rst_n),
                .line_i  (line_in[b*LW +: LW]),
                .wr_en   (bank_wr),
                .wr_kind (sel.kind),
                .wdata   (bus_wdata),
                .imask_o (imask_a[b]),
                .emask_o (emask_a[b]),
                .rise_o  (rise_a[b]),
                .fall_o  (fall_a[b]),
                .pend_o  (pend_a[b])
            );

            // Per-bank request and summary bits.
            always_comb begin
                bank_req[b]      = |(pend_a[b] & imask_a[b]);
                bank_en_any[b]   = |imask_a[b];
                bank_pend_any[b] = |pend_a[b];
            end
        end
    endgenerate

    // Single level interrupt across all banks.
    always_comb begin
        irq = |bank_req;
    end

    // Read mux: selected register of the selected bank; trigger reads zero.
    always_comb begin
        bus_rdata = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (sel.hit && sel.bank == BANK_IDX_W'(b)) begin
                case (sel.kind)
                    RK_IMASK: bus_rdata = imask_a[b];
                    RK_EMASK: bus_rdata = emask_a[b];
                    RK_RISE:  bus_rdata = rise_a[b];
                    RK_FALL:  bus_rdata = fall_a[b];
                    RK_PEND:  bus_rdata = pend_a[b];
                    default:  bus_rdata = '0;
                endcase
            end
        end
    end

    AST_MASK_BLOCKS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_en_any == '0) |-> !irq); // R9
    AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (bank_pend_any != '0)); // R9
    AST_UNMAPPED_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !sel.hit |-> (bus_rdata == '0)); // R11

endmodule

// File: tb/edge_irq_ctrl_test.sv
module edge_irq_ctrl_test;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int  NB       = 3;
    localparam int  LW       = 32;
    localparam real CLK_PER  = 10.0;
    localparam int  WATCHDOG = 50000;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              wr;
    logic [7:0]        addr;
    logic [31:0]       wdata;
    logic [31:0]       rdata;
    logic [NB*LW-1:0]  lines;
    logic              irq;

    logic              s_wr;
    logic [7:0]        s_addr;
    logic [31:0]       s_wdata;
    logic [31:0]       s_rdata;
    logic [LW-1:0]     s_lines;
    logic              s_irq;

    int total = 0;
    int fails = 0;
    bit done  = 0;

    // Model state per bank.
    logic [31:0] m_imask [NB];
    logic [31:0] m_emask [NB];
    logic [31:0] m_rise  [NB];
    logic [31:0] m_fall  [NB];
    logic [31:0] m_pend  [NB];
    logic [31:0] m_prev  [NB];

    always #(CLK_PER/2) clk = ~clk;

    edge_irq_ctrl #(.NUM_BANKS(NB), .ADDR_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(wr), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata), .line_in(lines), .irq(irq)
    );

    edge_irq_ctrl #(.NUM_BANKS(1), .ADDR_W(8)) uut_single (
        .clk(clk), .rst_n(rst_n), .bus_wr(s_wr), .bus_addr(s_addr),
        .bus_wdata(s_wdata), .bus_rdata(s_rdata), .line_in(s_lines), .irq(s_irq)
    );

    // Register kinds: 1 enable, 2 event, 3 rise, 4 fall, 5 trigger, 6 pending.
    function automatic logic [7:0] addr_of(int b, int k);
        case (k)
            1: return 8'(8'h80 + 16*b);
            2: return 8'(8'h84 + 16*b);
            3: return 8'(8'h00 + 32*b);
            4: return 8'(8'h04 + 32*b);
            5: return 8'(8'h08 + 32*b);
            default: return 8'(8'h88 + 16*b);
        endcase
    endfunction

    // Reverse lookup from the R12 split map; returns kind 0 when unmapped.
    function automatic void lookup(logic [7:0] a, output int b, output int k);
        b = 0; k = 0;
        for (int bb = 0; bb < NB; bb++)
            for (int kk = 1; kk <= 6; kk++)
                if (addr_of(bb, kk) == a) begin b = bb; k = kk; end
    endfunction

    function automatic logic [31:0] exp_read(logic [7:0] a);
        int b, k;
        lookup(a, b, k);
        case (k)
            1: return m_imask[b];
            2: return m_emask[b];
            3: return m_rise[b];
            4: return m_fall[b];
            6: return m_pend[b];
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic exp_irq();
        logic r = 1'b0;
        for (int b = 0; b < NB; b++) r |= |(m_pend[b] & m_imask[b]);
        return r;
    endfunction

    task automatic expect32(string tag, logic [31:0] got, logic [31:0] exp);
        total++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %08h expected %08h", tag, got, exp);
        end
    endtask

    // Advance the model by one clock using the inputs now driven.
    task automatic model_step();
        int wb, wk;
        lookup(addr, wb, wk);
        for (int b = 0; b < NB; b++) begin
            logic [31:0] ln  = lines[b*LW +: LW];
            logic [31:0] edg = (ln & ~m_prev[b] & m_rise[b]) | (~ln & m_prev[b] & m_fall[b]);
            logic [31:0] p   = m_pend[b];
            if (wr && wk != 0 && wb == b) begin
                case (wk)
                    1: m_imask[b] = wdata;
                    2: m_emask[b] = wdata;
                    3: m_rise[b]  = wdata;
                    4: m_fall[b]  = wdata;
                    5: p = p | wdata;
                    6: p = p & ~wdata;
                    default: ;
                endcase
            end
            m_pend[b] = p | edg;
            m_prev[b] = ln;
        end
    endtask

    task automatic cycle(logic w, logic [7:0] a, logic [31:0] d, logic [NB*LW-1:0] l);
        wr = w; addr = a; wdata = d; lines = l;
        model_step();
        @(posedge clk);
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] v);
        addr = a;
        #0.2;
        v = rdata;
    endtask

    // Compare every register of every bank and the request line.
    task automatic check_all(string tag);
        logic [31:0] v;
        wr = 1'b0;
        for (int b = 0; b < NB; b++)
            for (int k = 1; k <= 6; k++) begin
                rd(addr_of(b, k), v);
                expect32(tag, v, exp_read(addr_of(b, k)));
            end
        expect32({tag, " irq"}, 32'(irq), 32'(exp_irq()));
    endtask

    task automatic s_cycle(logic w, logic [7:0] a, logic [31:0] d);
        s_wr = w; s_addr = a; s_wdata = d;
        @(posedge clk);
        @(negedge clk);
        s_wr = 1'b0;
    endtask

    task automatic s_rd_check(string tag, logic [7:0] a, logic [31:0] exp);
        s_addr = a;
        #0.2;
        expect32(tag, s_rdata, exp);
    endtask

    // Watchdog: an expired run counts as one failure and still prints the summary.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [NB*LW-1:0] l;
        void'($urandom(32'd20240611));

        // R1: reset with some lines held high.
        rst_n = 1'b0; wr = 1'b0; addr = '0; wdata = '0;
        lines = {32'hFFFF_0000, 32'h00FF_00FF, 32'hF0F0_0F0F};
        s_wr = 1'b0; s_addr = '0; s_wdata = '0; s_lines = 32'h8000_0001;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int b = 0; b < NB; b++) begin
            m_imask[b] = '0; m_emask[b] = '0; m_rise[b] = '0;
            m_fall[b] = '0; m_pend[b] = '0; m_prev[b] = lines[b*LW +: LW];
        end
        check_all("R1");
        cycle(1'b0, 8'h00, 32'h0, lines);
        cycle(1'b0, 8'h00, 32'h0, lines);
        rd(8'h88, v); expect32("R1 pending after steady lines", v, 32'h0);
        expect32("R1 irq", 32'(irq), 32'h0);

        // R10: read-back of storage registers, including writing zero.
        cycle(1'b1, 8'h80, 32'hFFFF_FFFF, lines);
        cycle(1'b1, 8'h94, 32'h1234_5678, lines);
        cycle(1'b1, 8'h44, 32'hA5A5_0000, lines);
        cycle(1'b1, 8'h20, 32'h0000_5A5A, lines);
        check_all("R10");
        cycle(1'b1, 8'h80, 32'h0, lines);
        cycle(1'b1, 8'h44, 32'h0, lines);
        cycle(1'b1, 8'h20, 32'h0, lines);
        rd(8'h80, v); expect32("R10 enable cleared to zero", v, 32'h0);
        check_all("R10");

        // R2: bank0 bit3 rising only.
        l = lines; l[3] = 1'b0;
        cycle(1'b1, 8'h00, 32'h0000_0008, l);
        cycle(1'b1, 8'h88, 32'hFFFF_FFFF, l);
        l[3] = 1'b1; cycle(1'b0, 8'h00, 32'h0, l);
        rd(8'h88, v); expect32("R2 rise latched", v & 32'h8, 32'h8);
        cycle(1'b1, 8'h88, 32'h8, l);
        l[3] = 1'b0; cycle(1'b0, 8'h00, 32'h0, l);
        rd(8'h88, v); expect32("R2 fall ignored", v & 32'h8, 32'h0);
        check_all("R2");

        // R3: bank1 bit7 falling only.
        l[32+7] = 1'b0;
        cycle(1'b1, 8'h24, 32'h0000_0080, l);
        cycle(1'b1, 8'h98, 32'hFFFF_FFFF, l);
        l[32+7] = 1'b1; cycle(1'b0, 8'h00, 32'h0, l);
        rd(8'h98, v); expect32("R3 rise ignored", v & 32'h80, 32'h0);
        l[32+7] = 1'b0; cycle(1'b0, 8'h00, 32'h0, l);
        rd(8'h98, v); expect32("R3 fall latched", v & 32'h80, 32'h80);
        check_all("R3");

        // R4: bank2 bit31 both edges.
        cycle(1'b1, 8'h40, 32'h8000_0000, l);
        cycle(1'b1, 8'h44, 32'h8000_0000, l);
        cycle(1'b1, 8'hA8, 32'hFFFF_FFFF, l);
        l[64+31] = ~l[64+31]; cycle(1'b0, 8'h00, 32'h0, l);
        rd(8'hA8, v); expect32("R4 first change latched", v, 32'h8000_0000);
        cycle(1'b1, 8'hA8, 32'h8000_0000, l);
        l[64+31] = ~l[64+31]; cycle(1'b0, 8'h00, 32'h0, l);
        rd(8'hA8, v); expect32("R4 second change latched", v, 32'h8000_0000);
        check_all("R4");

        // R5: bank0 bit10 with no selects.
        cycle(1'b1, 8'h88, 32'hFFFF_FFFF, l);
        for (int i = 0; i < 4; i++) begin
            l[10] = ~l[10]; cycle(1'b0, 8'h00, 32'h0, l);
            rd(8'h88, v); expect32("R5 unarmed line", v & 32'h400, 32'h0);
        end

        // R6: partial write-one-to-clear.
        cycle(1'b1, 8'h08, 32'h0000_00F0, l);
        cycle(1'b1, 8'h88, 32'h0000_0030, l);
        rd(8'h88, v); expect32("R6 partial clear", v, 32'h0000_00C0);
        check_all("R6");

        // R7: edge and clear on the same bit in the same cycle (bit3 rise armed, low).
        cycle(1'b1, 8'h08, 32'h0000_0008, l);
        l[3] = 1'b1;
        cycle(1'b1, 8'h88, 32'h0000_0008, l);
        rd(8'h88, v); expect32("R7 edge beats clear", v & 32'h8, 32'h8);
        check_all("R7");

        // R8: software trigger on bank1 with no selects on that bit; reads zero.
        cycle(1'b1, 8'h28, 32'h0000_0100, l);
        rd(8'h98, v); expect32("R8 trigger sets pending", v & 32'h100, 32'h100);
        rd(8'h28, v); expect32("R8 trigger reads zero", v, 32'h0);

        // R9: enable gating keeps pending.
        cycle(1'b1, 8'h80, 32'h0, l);
        cycle(1'b1, 8'h90, 32'h0, l);
        cycle(1'b1, 8'hA0, 32'h0, l);
        expect32("R9 all disabled", 32'(irq), 32'h0);
        rd(8'h98, v); expect32("R9 pending kept", v & 32'h100, 32'h100);
        cycle(1'b1, 8'h90, 32'h0000_0100, l);
        expect32("R9 enabled line raises irq", 32'(irq), 32'h1);
        for (int b = 0; b < NB; b++) cycle(1'b1, addr_of(b, 6), 32'hFFFF_FFFF, l);
        expect32("R9 cleared drops irq", 32'(irq), 32'(exp_irq()));
        check_all("R9");

        // R11: unmapped and misaligned accesses.
        cycle(1'b1, 8'h0C, 32'hDEAD_BEEF, l);
        cycle(1'b1, 8'h60, 32'hDEAD_BEEF, l);
        cycle(1'b1, 8'hB0, 32'hDEAD_BEEF, l);
        cycle(1'b1, 8'h81, 32'hDEAD_BEEF, l);
        cycle(1'b1, 8'hC4, 32'hDEAD_BEEF, l);
        rd(8'h60, v); expect32("R11 unmapped read", v, 32'h0);
        rd(8'h81, v); expect32("R11 misaligned read", v, 32'h0);
        rd(8'hB8, v); expect32("R11 absent bank read", v, 32'h0);
        check_all("R11");

        // Random mix of line toggles and writes against the model.
        for (int i = 0; i < 1500; i++) begin
            logic [7:0] a;
            logic [31:0] d;
            logic w;
            for (int b = 0; b < NB; b++) l[b*LW +: LW] ^= ($urandom & $urandom & $urandom);
            w = ($urandom_range(0, 9) < 4);
            if ($urandom_range(0, 19) == 0) a = 8'($urandom_range(0, 255));
            else a = addr_of(int'($urandom_range(0, NB-1)), int'($urandom_range(1, 6)));
            d = $urandom;
            if (a == addr_of(0, 6) || a == addr_of(1, 6) || a == addr_of(2, 6)) d = d & $urandom;
            cycle(w, a, d, l);
            expect32("R9 irq random", 32'(irq), 32'(exp_irq()));
            if (i % 16 == 15) check_all("R2 R3 R4 R6 R8 random");
        end

        // R12: compact map on the single-bank instance.
        s_cycle(1'b1, 8'h00, 32'h0000_0001);
        s_cycle(1'b1, 8'h04, 32'hCAFE_0000);
        s_cycle(1'b1, 8'h08, 32'h0000_0002);
        s_cycle(1'b1, 8'h0C, 32'h0000_0004);
        s_rd_check("R12 enable at 0x00", 8'h00, 32'h0000_0001);
        s_rd_check("R12 event at 0x04", 8'h04, 32'hCAFE_0000);
        s_rd_check("R12 rise at 0x08", 8'h08, 32'h0000_0002);
        s_rd_check("R12 fall at 0x0C", 8'h0C, 32'h0000_0004);
        s_rd_check("R12 pending idle", 8'h14, 32'h0);
        s_lines[1] = 1'b1; s_lines[2] = 1'b1;
        s_cycle(1'b0, 8'h00, 32'h0);
        s_rd_check("R12 rise latched at 0x14", 8'h14, 32'h0000_0002);
        s_cycle(1'b1, 8'h10, 32'h0000_0001);
        s_rd_check("R12 trigger at 0x10", 8'h14, 32'h0000_0003);
        s_rd_check("R12 trigger reads zero", 8'h10, 32'h0);
        expect32("R12 single irq", 32'(s_irq), 32'h1);
        s_rd_check("R12 0x80 unmapped in compact map", 8'h80, 32'h0);

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule